// File: doc/BRIEF.md
# Three-Channel Timer Input Capture Unit

This block timestamps external events against a 16-bit free-running counter. Each of three channels watches one input pin. The pin passes through a two-flop synchronizer and a history flop, and a per-channel select decides which transitions count as events. When an event is recognised, the channel copies the whole counter value into its 16-bit holding register in a single step. Software reads each holding register over an 8-bit read-only bus as two bytes, high byte first.

The counter and the capture transfers take turns. A two-state timebase alternates between PH_COUNT, where the counter advances at the end of the cycle, and PH_SAMPLE, where captures may complete while the counter is held. Reading a channel's high byte shuts a per-channel gate. While the gate is shut, no new value can land in that channel, so the low byte read next still belongs to the same capture.

Each channel's gate state machine has two states. GATE_OPEN moves to GATE_SHUT on a high-byte read ("lock"). GATE_SHUT stays shut on another high-byte read ("relock") and otherwise returns to GATE_OPEN ("unlock").

Each channel's capture state machine also has two states:
- CAP_ARMED keeps its state when an event meets a free sample slot ("direct"; the transfer happens). It moves to CAP_PENDING when the slot is not free ("defer").
- CAP_PENDING returns to CAP_ARMED at the first free sample slot ("release"; the transfer happens) and otherwise stays ("wait").

Top module: `icap_unit`

## Requirements
- R1: A synchronous active-low reset puts the timebase in PH_COUNT with the counter at 0, every capture FSM in CAP_ARMED and every gate in GATE_OPEN. It also loads every synchronizer stage with the current pin level, so the pin level seen at reset is not an event. Counting cycles from 0 at the first cycle after release, the counter reads 0 in cycle 0.
- R2: In cycle k after reset release, `count_o` equals floor((k+1)/2). The counter advances by one at the end of every even cycle and holds across odd cycles.
- R3: A pin change driven during cycle p is recognised as an event in cycle p+2 and not earlier.
- R4: The 2-bit select of channel i sits at `edge_sel[2i+1:2i]`: 00 = no events, 01 = rising only, 10 = falling only, 11 = both. A transition that is not selected never changes the holding register.
- R5: Transfers complete only at the end of odd cycles, and each one stores the full 16-bit counter value of that cycle in one step. An unblocked event recognised in cycle e is stored at the end of the first odd cycle c ≥ e, with value (c+1)/2.
- R6: Read data is combinational in the cycle `rd_en` is high. Channel i's high byte is at address 0x10+2i and its low byte at 0x11+2i, giving 0x10–0x15 for channels 0–2. Any other address, or `rd_en` low, returns 0x00.
- R7: A high-byte read of channel i in cycle N blocks transfers into channel i at the ends of cycles N and N+1. Other channels are unaffected, and a low-byte read in cycle N+1 returns the byte that matches the high byte read in cycle N.
- R8: A blocked event is not lost. It is held in CAP_PENDING and transferred at the first free odd cycle, storing the counter value of that later cycle.
- R9: Events recognised while a channel is in CAP_PENDING are ignored, and the pending event produces exactly one transfer.
- R10: A low-byte read never blocks or delays a transfer.
- R11: Reset leaves the holding registers unchanged. With steady pins, leaving reset causes no capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_pin | input | 3 | Asynchronous event inputs, bit i for channel i |
| edge_sel | input | 6 | Event select, two bits per channel |
| rd_en | input | 1 | Read strobe for the current cycle |
| rd_addr | input | 8 | Byte address of the read |
| rd_data | output | 8 | Read data, valid in the strobed cycle |
| count_o | output | 16 | Free-running counter value |

## Verification
The bench places events so that they are recognised in odd cycles and aims high-byte reads at exactly those cycles. A design without the gate would store the counter value one slot early, and would return a low byte from the new capture after the high byte of the old one. A design that drops blocked events would keep the stale value. One that samples the counter at event time rather than at transfer time would store a value one step too low. Unselected edges, events arriving during a pending capture, isolated low-byte reads and a mid-run reset are each followed by bus reads, which show whether a stray transfer occurred. Capture values are taken beyond cycle 1000 so that both bytes carry nonzero data.

// File: rtl/icap_pkg.sv
package icap_pkg;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_ANY  = 2'b11
    } edge_mode_e;

    typedef enum logic {
        PH_COUNT,
        PH_SAMPLE
    } phase_e;

    typedef enum logic {
        CAP_ARMED,
        CAP_PENDING
    } cap_state_e;

    typedef enum logic {
        GATE_OPEN,
        GATE_SHUT
    } gate_state_e;

endpackage

// File: rtl/icap_timebase.sv
module icap_timebase
    import icap_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             sample_slot,
    output logic [CNT_W-1:0] count
);

    phase_e ph_q;
    phase_e ph_d;
    logic   advance;

    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= PH_COUNT;
        else        ph_q <= ph_d;
    end

    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_COUNT:  ph_d = PH_SAMPLE;
            PH_SAMPLE: ph_d = PH_COUNT;
            default:   ph_d = PH_COUNT;
        endcase
    end

    always_comb begin
        advance     = 1'b0;
        sample_slot = 1'b0;
        unique case (ph_q)
            PH_COUNT:  advance     = 1'b1;
            PH_SAMPLE: sample_slot = 1'b1;
            default:   advance     = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       count <= '0;
        else if (advance) count <= count + 1'b1;
    end

endmodule

// File: rtl/icap_sync_edge.sv
module icap_sync_edge
    import icap_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin,
    input  edge_mode_e mode,
    output logic       edge_hit
);

    localparam int DEPTH = SYNC_STAGES + 1;

    logic [DEPTH-1:0] chain;
    logic             level_now;
    logic             level_old;
    logic             rose;
    logic             fell;

    // During reset every stage follows the pin, so no event appears on release.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {DEPTH{pin}};
        else        chain <= {chain[DEPTH-2:0], pin};
    end

    assign level_now = chain[SYNC_STAGES-1];
    assign level_old = chain[SYNC_STAGES];
    assign rose      = level_now & ~level_old;
    assign fell      = ~level_now & level_old;

    always_comb begin
        edge_hit = 1'b0;
        unique case (mode)
            EDGE_OFF:  edge_hit = 1'b0;
            EDGE_RISE: edge_hit = rose;
            EDGE_FALL: edge_hit = fell;
            EDGE_ANY:  edge_hit = rose | fell;
            default:   edge_hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/icap_channel.sv
module icap_channel
    import icap_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_hit,
    input  logic             sample_slot,
    input  logic             hi_read,
    input  logic [CNT_W-1:0] count,
    output logic             xfer,
    output logic [CNT_W-1:0] hold_q
);

    gate_state_e gate_q;
    gate_state_e gate_d;
    cap_state_e  cap_q;
    cap_state_e  cap_d;
    logic        slot_free;

    // Gate: shut for the cycle after any high-byte read.
    always_ff @(posedge clk) begin
        if (!rst_n) gate_q <= GATE_OPEN;
        else        gate_q <= gate_d;
    end

    always_comb begin
        gate_d = gate_q;
        unique case (gate_q)
            GATE_OPEN: gate_d = hi_read ? GATE_SHUT : GATE_OPEN;  // lock
            GATE_SHUT: gate_d = hi_read ? GATE_SHUT : GATE_OPEN;  // relock / unlock
            default:   gate_d = GATE_OPEN;
        endcase
    end

    assign slot_free = sample_slot && !hi_read && (gate_q == GATE_OPEN);

    // Capture FSM.
    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= CAP_ARMED;
        else        cap_q <= cap_d;
    end

    always_comb begin
        cap_d = cap_q;
        unique case (cap_q)
            CAP_ARMED:   if (edge_hit && !slot_free) cap_d = CAP_PENDING;  // defer
            CAP_PENDING: if (slot_free)              cap_d = CAP_ARMED;    // release
            default:     cap_d = CAP_ARMED;
        endcase
    end

    always_comb begin
        xfer = 1'b0;
        unique case (cap_q)
            CAP_ARMED:   xfer = edge_hit && slot_free;  // direct
            CAP_PENDING: xfer = slot_free;              // later edges ignored
            default:     xfer = 1'b0;
        endcase
    end

    // Holding register: no reset, written only by a transfer.
    always_ff @(posedge clk) begin
        if (xfer) hold_q <= count;
    end

endmodule

// File: rtl/icap_bus_decode.sv
module icap_bus_decode #(
    parameter int NCH       = 3,
    parameter int CNT_W     = 16,
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 8,
    parameter int BASE_ADDR = 16
) (
    input  logic                       rd_en,
    input  logic [ADDR_W-1:0]          rd_addr,
    input  logic [NCH-1:0][CNT_W-1:0]  hold_vals,
    output logic [NCH-1:0]             hi_read,
    output logic [DATA_W-1:0]          rd_data
);

    logic [NCH-1:0] lo_hit;

    for (genvar g = 0; g < NCH; g++) begin : g_map
        localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(BASE_ADDR + 2 * g);
        localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(BASE_ADDR + 2 * g + 1);
        assign hi_read[g] = rd_en && (rd_addr == HI_ADDR);
        assign lo_hit[g]  = rd_en && (rd_addr == LO_ADDR);
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NCH; i++) begin
            if (hi_read[i]) rd_data = hold_vals[i][CNT_W-1 -: DATA_W];
            if (lo_hit[i])  rd_data = hold_vals[i][DATA_W-1:0];
        end
    end

endmodule

// File: rtl/icap_unit.sv
module icap_unit
    import icap_pkg::*;
#(
    parameter int NCH         = 3,
    parameter int CNT_W       = 16,
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 8,
    parameter int BASE_ADDR   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NCH-1:0]     cap_pin,
    input  logic [2*NCH-1:0]   edge_sel,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    output logic [CNT_W-1:0]   count_o
);

    logic                      sample_slot;
    logic [NCH-1:0]            hi_read;
    logic [NCH-1:0]            edge_hit;
    logic [NCH-1:0]            xfer;
    logic [NCH-1:0][CNT_W-1:0] hold_vals;

    icap_timebase #(.CNT_W(CNT_W)) u_timebase (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_slot (sample_slot),
        .count       (count_o)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        icap_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin      (cap_pin[g]),
            .mode     (edge_mode_e'(edge_sel[2*g +: 2])),
            .edge_hit (edge_hit[g])
        );

        icap_channel #(.CNT_W(CNT_W)) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .edge_hit    (edge_hit[g]),
            .sample_slot (sample_slot),
            .hi_read     (hi_read[g]),
            .count       (count_o),
            .xfer        (xfer[g]),
            .hold_q      (hold_vals[g])
        );
    end

    icap_bus_decode #(
        .NCH       (NCH),
        .CNT_W     (CNT_W),
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_decode (
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .hold_vals (hold_vals),
        .hi_read   (hi_read),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/icap_unit_chk.sv
module icap_unit_chk #(
    parameter int NCH    = 3,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      rd_en,
    input logic [DATA_W-1:0]         rd_data,
    input logic [CNT_W-1:0]          count_o,
    input logic                      sample_slot,
    input logic [NCH-1:0]            hi_read,
    input logic [NCH-1:0]            xfer,
    input logic [NCH-1:0][CNT_W-1:0] hold_vals
);

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_slot |=> count_o == CNT_W'($past(count_o) + 1'b1));

    assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sample_slot |=> $stable(count_o));

    assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> rd_data == '0);

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        assert_slot_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
            xfer[g] |-> sample_slot);

        assert_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
            xfer[g] |=> hold_vals[g] == $past(count_o));

        assert_block_now_R7: assert property (@(posedge clk) disable iff (!rst_n)
            hi_read[g] |-> !xfer[g]);

        assert_block_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
            hi_read[g] |=> !xfer[g]);
    end

endmodule

bind icap_unit icap_unit_chk #(
    .NCH    (NCH),
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_en       (rd_en),
    .rd_data     (rd_data),
    .count_o     (count_o),
    .sample_slot (sample_slot),
    .hi_read     (hi_read),
    .xfer        (xfer),
    .hold_vals   (hold_vals)
);

// File: tb/icap_unit_test.sv
`timescale 1ns/1ps
module icap_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cap_pin = '0;
    logic [5:0]  edge_sel = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic [15:0] count_o;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    icap_unit uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_pin  (cap_pin),
        .edge_sel (edge_sel),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .count_o  (count_o)
    );

    // Cycle index since reset release; at a falling edge it names the current cycle.
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic goto(input int k);
        while (cyc < k) @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        rd_en   = 1'b1;
        rd_addr = a;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic check_pair(input string req, input logic [7:0] hi_a, input int exp);
        logic [7:0] h;
        logic [7:0] l;
        rd(hi_a, h);
        rd(hi_a + 8'd1, l);
        chk(req, {h, l}, exp);
    endtask

    // First odd cycle at or after recognition (p+2) holds the value (c+1)/2.
    function automatic int exp_cap(input int p);
        int c = p + 2;
        if (c % 2 == 0) c++;
        return (c + 1) / 2;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_count();
        #1 chk("R1 counter zero in cycle 0", count_o, 0);
        goto(5);
        #1 chk("R2 counter in cycle 5", count_o, 3);
        goto(8);
        #1 chk("R2 counter in cycle 8", count_o, 4);
    endtask

    task automatic t_basic_capture();
        edge_sel[1:0] = 2'b01;
        goto(10);
        cap_pin[0] = 1'b1;
        goto(20);
        check_pair("R3 R5 ch0 rise latency", 8'h10, exp_cap(10));
    endtask

    task automatic t_edge_select();
        goto(25);
        edge_sel[3:2] = 2'b11;
        goto(30);
        cap_pin[1] = 1'b1;
        goto(40);
        check_pair("R4 both-edge mode rise", 8'h12, exp_cap(30));
        goto(45);
        edge_sel[3:2] = 2'b10;
        goto(50);
        cap_pin[1] = 1'b0;
        goto(60);
        check_pair("R4 falling mode fall", 8'h12, exp_cap(50));
        goto(70);
        cap_pin[1] = 1'b1;
        goto(80);
        check_pair("R4 falling mode ignores rise", 8'h12, exp_cap(50));
        goto(85);
        edge_sel[3:2] = 2'b00;
        goto(90);
        cap_pin[1] = 1'b0;
        goto(100);
        check_pair("R4 disabled mode ignores fall", 8'h12, exp_cap(50));
    endtask

    task automatic t_address_map();
        logic [7:0] d;
        goto(110);
        rd(8'h0F, d); chk("R6 unmapped 0x0F", d, 0);
        rd(8'h16, d); chk("R6 unmapped 0x16", d, 0);
        rd(8'h00, d); chk("R6 unmapped 0x00", d, 0);
        rd_addr = 8'h11;
        #1 chk("R6 rd_en low returns zero", rd_data, 0);
    endtask

    task automatic t_read_inhibit();
        logic [7:0] h;
        logic [7:0] l;
        goto(1100);
        edge_sel[5:4] = 2'b01;
        goto(1150);
        cap_pin[2] = 1'b1;   // ch2 -> 577
        cap_pin[0] = 1'b0;   // rising-only ch0 ignores this
        goto(1170);
        cap_pin[2] = 1'b0;
        goto(1201);
        cap_pin[2] = 1'b1;   // recognised in odd cycle 1203
        cap_pin[0] = 1'b1;
        goto(1203);
        rd(8'h14, h);        // high read in 1203
        rd(8'h15, l);        // low read in 1204
        chk("R7 coherent high byte", h, 8'h02);
        chk("R7 coherent low byte", l, 8'h41);
        goto(1230);
        check_pair("R8 deferred value from transfer cycle", 8'h14, 16'h025B);
        check_pair("R7 other channel unaffected", 8'h10, 16'h025A);
    endtask

    task automatic t_pending();
        logic [7:0] d;
        goto(1280);
        edge_sel[3:2] = 2'b11;
        goto(1301);
        cap_pin[1] = 1'b1;   // recognised in 1303
        goto(1302);
        cap_pin[1] = 1'b0;   // recognised in 1304 while pending
        rd(8'h12, d); chk("R7 old high byte in 1302", d, 8'h00);
        rd(8'h12, d);
        rd(8'h12, d);
        rd(8'h12, d); chk("R8 still blocked in 1305", d, 8'h00);
        goto(1320);
        check_pair("R8 R9 single deferred transfer", 8'h12, 16'h028E);
        goto(1340);
        check_pair("R9 no second transfer", 8'h12, 16'h028E);
    endtask

    task automatic t_low_read();
        logic [7:0] d;
        goto(1350);
        cap_pin[2] = 1'b0;
        goto(1401);
        cap_pin[2] = 1'b1;   // recognised in 1403
        goto(1402);
        rd(8'h15, d);
        rd(8'h15, d); chk("R10 low read sees old value", d, 8'h5B);
        goto(1420);
        check_pair("R10 low reads do not delay", 8'h14, 16'h02BE);
    endtask

    task automatic t_reset_keeps();
        goto(1450);
        do_reset();
        #1 chk("R1 counter zero after second reset", count_o, 0);
        goto(20);
        check_pair("R11 ch0 kept through reset", 8'h10, 16'h025A);
        check_pair("R11 ch1 kept through reset", 8'h12, 16'h028E);
        check_pair("R11 ch2 kept through reset", 8'h14, 16'h02BE);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset_count();
        t_basic_capture();
        t_edge_select();
        t_address_map();
        t_read_inhibit();
        t_pending();
        t_low_read();
        t_reset_keeps();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule